// File: doc/BRIEF.md
# ECC Fault Capture Register File

This block keeps a diagnostic record of the first memory read that an error-correcting decoder reports as faulty. Two strobes arrive from the decoder, one for a correctable (single-bit) fault and one for an uncorrectable (double-bit) fault. With them come the 23-bit global address of the access, the 64-bit data word, the parity bits, and a flag that says whether the access went to the wide memory (64 data bits, 8 parity bits) or to the narrow memory (16 data bits, 6 parity bits). The first fault of each kind is latched together with a sticky flag. The record is then held until software clears that flag.

Double-bit faults rank above single-bit faults. When both strobes arrive together, the double-bit fault is the one recorded. A double-bit fault may replace a held single-bit record, but never the other way round. The record is read through a 16-bit read-only window, and a 3-bit index selects which slice appears on it. Fields that do not exist for the narrow memory type read as zero.

Top module: `ecc_fault_capture`

## Requirements
- R1: After reset, both fault flags are 0 and every window index reads 0x0000.
- R2: A double-bit strobe with the double-bit flag clear and no double-bit clear in that cycle sets the double-bit flag in the next cycle and captures address, data and parity.
- R3: A single-bit strobe is accepted only when both flags are clear, no single-bit clear is present and no double-bit strobe is accepted in the same cycle. An accepted single-bit strobe sets the single-bit flag in the next cycle and captures the record.
- R4: While the single-bit flag is held, further single-bit strobes change neither the record nor the flags.
- R5: While the double-bit flag is held, no strobe of either kind changes the record, and a single-bit strobe does not set the single-bit flag.
- R6: When both strobes are accepted together, the double-bit information is recorded and only the double-bit flag becomes set.
- R7: A double-bit strobe that arrives while only the single-bit flag is held overwrites the record, and the single-bit flag stays set.
- R8: A one-cycle clear pulse drops its flag in the next cycle. If a strobe of the same kind arrives in that cycle, the clear wins and nothing is captured.
- R9: Index 0 returns the parity bits in [15:8], 0 in bit 7 and address bits [22:16] in [6:0]. Index 1 returns address bits [15:0].
- R10: Indexes 2, 3, 4 and 5 return data bits [15:0], [31:16], [47:32] and [63:48] of the captured word.
- R11: Indexes 6 and 7 always read 0x0000.
- R12: For a capture with the wide select at 0 (narrow type), parity bits [7:6] read 0 and indexes 3 to 5 read 0x0000. With the select at 1, all 8 parity bits and all 64 data bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sbe_strobe | input | 1 | Single-bit (corrected) fault report |
| dbe_strobe | input | 1 | Double-bit (uncorrectable) fault report |
| fault_addr | input | 23 | Global address of the faulting read |
| fault_data | input | 64 | Data word of the faulting read |
| fault_par | input | 8 | Parity bits of the faulting read |
| wide_sel | input | 1 | 1: wide memory type, 0: narrow memory type |
| sbe_clr | input | 1 | Clear pulse for the single-bit flag |
| dbe_clr | input | 1 | Clear pulse for the double-bit flag |
| win_idx | input | 3 | Readout slice select |
| win_rdata | output | 16 | Selected 16-bit slice of the record |
| sbe_flag | output | 1 | Single-bit fault recorded |
| dbe_flag | output | 1 | Double-bit fault recorded |

## Verification
The assertions check the cycle-level rules on every cycle:
- each flag rises after an accepted strobe and falls after its clear;
- the record stays frozen while a double-bit record is held, and while a single-bit record is held with no double-bit strobe;
- simultaneous strobes leave the single-bit flag clear;
- unused indexes and bit 7 of index 0 read zero.

Only the bench scenarios can show that the captured slices match the address, data and parity that were presented, with narrow-type masking. The same holds for the overwrite of a single-bit record by a double-bit one and for a clear beating a same-cycle strobe over long random sequences.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
   // Kind of capture decided in a cycle
   typedef enum logic [1:0] {
      CAP_NONE   = 2'd0,
      CAP_SINGLE = 2'd1,
      CAP_DOUBLE = 2'd2
   } cap_kind_e;

   // Fixed window layout positions
   localparam int unsigned IDX_PAR_AHI = 0;
   localparam int unsigned IDX_ALO     = 1;
   localparam int unsigned IDX_DATA0   = 2;
endpackage

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl
   import ecc_cap_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sbe_strobe,
   input  logic      dbe_strobe,
   input  logic      sbe_clr,
   input  logic      dbe_clr,
   output logic      sbe_flag,
   output logic      dbe_flag,
   output logic      cap_en,
   output cap_kind_e cap_kind
);
   logic take_dbl;
   logic take_sgl;

   // Double-bit wins; clear of a flag blocks a new capture of that kind.
   assign take_dbl = dbe_strobe & ~dbe_flag & ~dbe_clr;
   assign take_sgl = sbe_strobe & ~sbe_flag & ~sbe_clr & ~dbe_flag & ~take_dbl;

   always_comb begin
      if (take_dbl)      cap_kind = CAP_DOUBLE;
      else if (take_sgl) cap_kind = CAP_SINGLE;
      else               cap_kind = CAP_NONE;
   end

   assign cap_en = (cap_kind != CAP_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sbe_flag <= 1'b0;
         dbe_flag <= 1'b0;
      end else begin
         if (sbe_clr)       sbe_flag <= 1'b0;
         else if (take_sgl) sbe_flag <= 1'b1;
         if (dbe_clr)       dbe_flag <= 1'b0;
         else if (take_dbl) dbe_flag <= 1'b1;
      end
   end
endmodule

// File: rtl/ecc_cap_store.sv
module ecc_cap_store #(
   parameter int unsigned ADDR_W   = 23,
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned PAR_W    = 8,
   parameter int unsigned N_PAR_W  = 6,
   parameter int unsigned N_DATA_W = 16,
   parameter int unsigned SLICE_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              wide_sel,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   input  logic [PAR_W-1:0]  in_par,
   output logic [ADDR_W-1:0] rec_addr,
   output logic [DATA_W-1:0] rec_data,
   output logic [PAR_W-1:0]  rec_par
);
   localparam int unsigned N_SLICE = DATA_W / SLICE_W;

   logic [DATA_W-1:0] kept_data;
   logic [PAR_W-1:0]  kept_par;

   // Per-slice narrow masking: slices wholly beyond the narrow width vanish
   for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
      localparam int unsigned LO = s * SLICE_W;
      for (genvar b = 0; b < SLICE_W; b++) begin : g_bit
         if (LO + b < N_DATA_W) begin : g_keep
            assign kept_data[LO+b] = in_data[LO+b];
         end else begin : g_mask
            assign kept_data[LO+b] = wide_sel & in_data[LO+b];
         end
      end
   end

   for (genvar p = 0; p < PAR_W; p++) begin : g_par
      if (p < N_PAR_W) begin : g_keep
         assign kept_par[p] = in_par[p];
      end else begin : g_mask
         assign kept_par[p] = wide_sel & in_par[p];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_addr <= '0;
         rec_data <= '0;
         rec_par  <= '0;
      end else if (cap_en) begin
         rec_addr <= in_addr;
         rec_data <= kept_data;
         rec_par  <= kept_par;
      end
   end
endmodule

// File: rtl/ecc_cap_window.sv
module ecc_cap_window
   import ecc_cap_pkg::*;
#(
   parameter int unsigned ADDR_W  = 23,
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned PAR_W   = 8,
   parameter int unsigned SLICE_W = 16,
   parameter int unsigned IDX_W   = 3
) (
   input  logic [IDX_W-1:0]   win_idx,
   input  logic [ADDR_W-1:0]  rec_addr,
   input  logic [DATA_W-1:0]  rec_data,
   input  logic [PAR_W-1:0]   rec_par,
   output logic [SLICE_W-1:0] win_rdata
);
   localparam int unsigned N_WORD  = 1 << IDX_W;
   localparam int unsigned N_SLICE = DATA_W / SLICE_W;
   localparam int unsigned AHI_W   = ADDR_W - SLICE_W;
   localparam int unsigned GAP_W   = SLICE_W - PAR_W - AHI_W;

   logic [SLICE_W-1:0] words [N_WORD];

   for (genvar k = 0; k < N_WORD; k++) begin : g_word
      if (k == IDX_PAR_AHI) begin : g_parhi
         assign words[k] = {rec_par, {GAP_W{1'b0}}, rec_addr[ADDR_W-1:SLICE_W]};
      end else if (k == IDX_ALO) begin : g_alo
         assign words[k] = rec_addr[SLICE_W-1:0];
      end else if (k >= IDX_DATA0 && k < IDX_DATA0 + N_SLICE) begin : g_data
         assign words[k] = rec_data[(k-IDX_DATA0)*SLICE_W +: SLICE_W];
      end else begin : g_unused
         assign words[k] = '0;
      end
   end

   assign win_rdata = words[win_idx];
endmodule

// File: rtl/ecc_fault_capture.sv
module ecc_fault_capture
   import ecc_cap_pkg::*;
#(
   parameter int unsigned ADDR_W   = 23,
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned PAR_W    = 8,
   parameter int unsigned N_PAR_W  = 6,
   parameter int unsigned N_DATA_W = 16,
   parameter int unsigned SLICE_W  = 16,
   parameter int unsigned IDX_W    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sbe_strobe,
   input  logic               dbe_strobe,
   input  logic [ADDR_W-1:0]  fault_addr,
   input  logic [DATA_W-1:0]  fault_data,
   input  logic [PAR_W-1:0]   fault_par,
   input  logic               wide_sel,
   input  logic               sbe_clr,
   input  logic               dbe_clr,
   input  logic [IDX_W-1:0]   win_idx,
   output logic [SLICE_W-1:0] win_rdata,
   output logic               sbe_flag,
   output logic               dbe_flag
);
   localparam int unsigned N_SLICE = DATA_W / SLICE_W;

   // Elaboration-time parameter checks
   if (ADDR_W <= SLICE_W || ADDR_W > 2 * SLICE_W) begin : g_chk_addr
      $error("ADDR_W must span more than one and at most two slices");
   end
   if (PAR_W + 1 + (ADDR_W - SLICE_W) > SLICE_W) begin : g_chk_pack
      $error("parity, gap bit and upper address do not fit one slice");
   end
   if (DATA_W % SLICE_W != 0) begin : g_chk_data
      $error("DATA_W must be a multiple of SLICE_W");
   end
   if (IDX_DATA0 + N_SLICE > (1 << IDX_W)) begin : g_chk_idx
      $error("index width too small for all slices");
   end
   if (N_PAR_W > PAR_W || N_DATA_W > DATA_W) begin : g_chk_narrow
      $error("narrow widths exceed wide widths");
   end

   logic              cap_en;
   cap_kind_e         cap_kind;
   logic [ADDR_W-1:0] rec_addr;
   logic [DATA_W-1:0] rec_data;
   logic [PAR_W-1:0]  rec_par;

   ecc_cap_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sbe_strobe (sbe_strobe),
      .dbe_strobe (dbe_strobe),
      .sbe_clr    (sbe_clr),
      .dbe_clr    (dbe_clr),
      .sbe_flag   (sbe_flag),
      .dbe_flag   (dbe_flag),
      .cap_en     (cap_en),
      .cap_kind   (cap_kind)
   );

   ecc_cap_store #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .PAR_W    (PAR_W),
      .N_PAR_W  (N_PAR_W),
      .N_DATA_W (N_DATA_W),
      .SLICE_W  (SLICE_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .wide_sel (wide_sel),
      .in_addr  (fault_addr),
      .in_data  (fault_data),
      .in_par   (fault_par),
      .rec_addr (rec_addr),
      .rec_data (rec_data),
      .rec_par  (rec_par)
   );

   ecc_cap_window #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .PAR_W   (PAR_W),
      .SLICE_W (SLICE_W),
      .IDX_W   (IDX_W)
   ) u_window (
      .win_idx   (win_idx),
      .rec_addr  (rec_addr),
      .rec_data  (rec_data),
      .rec_par   (rec_par),
      .win_rdata (win_rdata)
   );
endmodule

// File: rtl/ecc_cap_chk.sv
module ecc_cap_chk #(
   parameter int unsigned ADDR_W  = 23,
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned PAR_W   = 8,
   parameter int unsigned SLICE_W = 16,
   parameter int unsigned IDX_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sbe_strobe,
   input logic               dbe_strobe,
   input logic               sbe_clr,
   input logic               dbe_clr,
   input logic               sbe_flag,
   input logic               dbe_flag,
   input logic [IDX_W-1:0]   win_idx,
   input logic [SLICE_W-1:0] win_rdata,
   input logic [ADDR_W-1:0]  rec_addr,
   input logic [DATA_W-1:0]  rec_data,
   input logic [PAR_W-1:0]   rec_par
);
   localparam int unsigned UNUSED_FROM = 2 + DATA_W / SLICE_W;

   a_r2_dbe_sets : assert property (@(posedge clk) disable iff (!rst_n)
      dbe_strobe && !dbe_flag && !dbe_clr |=> dbe_flag);

   a_r4_sbe_hold : assert property (@(posedge clk) disable iff (!rst_n)
      sbe_flag && !dbe_strobe |=> $stable(rec_addr) && $stable(rec_data) && $stable(rec_par));

   a_r5_dbe_hold : assert property (@(posedge clk) disable iff (!rst_n)
      dbe_flag |=> $stable(rec_addr) && $stable(rec_data) && $stable(rec_par));

   a_r5_no_sbe_flag : assert property (@(posedge clk) disable iff (!rst_n)
      dbe_flag && !sbe_flag |=> !sbe_flag);

   a_r6_dbl_first : assert property (@(posedge clk) disable iff (!rst_n)
      sbe_strobe && dbe_strobe && !dbe_flag && !dbe_clr && !sbe_flag |=> !sbe_flag);

   a_r7_keep_sbe : assert property (@(posedge clk) disable iff (!rst_n)
      sbe_flag && !sbe_clr && dbe_strobe && !dbe_flag && !dbe_clr |=> sbe_flag && dbe_flag);

   a_r8_sbe_clr : assert property (@(posedge clk) disable iff (!rst_n)
      sbe_clr |=> !sbe_flag);

   a_r8_dbe_clr : assert property (@(posedge clk) disable iff (!rst_n)
      dbe_clr |=> !dbe_flag);

   a_r9_gap_bit : assert property (@(posedge clk) disable iff (!rst_n)
      win_idx == '0 |-> win_rdata[SLICE_W-PAR_W-1] == 1'b0);

   a_r11_unused : assert property (@(posedge clk) disable iff (!rst_n)
      int'(win_idx) >= UNUSED_FROM |-> win_rdata == '0);
endmodule

bind ecc_fault_capture ecc_cap_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .PAR_W   (PAR_W),
   .SLICE_W (SLICE_W),
   .IDX_W   (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sbe_strobe (sbe_strobe),
   .dbe_strobe (dbe_strobe),
   .sbe_clr    (sbe_clr),
   .dbe_clr    (dbe_clr),
   .sbe_flag   (sbe_flag),
   .dbe_flag   (dbe_flag),
   .win_idx    (win_idx),
   .win_rdata  (win_rdata),
   .rec_addr   (rec_addr),
   .rec_data   (rec_data),
   .rec_par    (rec_par)
);

// File: tb/sim_ecc_fault_capture.sv
`timescale 1ns/1ps
module sim_ecc_fault_capture;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sbe_strobe = 1'b0, dbe_strobe = 1'b0;
   logic [22:0] fault_addr = '0;
   logic [63:0] fault_data = '0;
   logic [7:0]  fault_par = '0;
   logic        wide_sel = 1'b0;
   logic        sbe_clr = 1'b0, dbe_clr = 1'b0;
   logic [2:0]  win_idx = '0;
   logic [15:0] win_rdata;
   logic        sbe_flag, dbe_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Reference record kept by the bench
   bit          m_sf, m_df;
   logic [22:0] m_addr;
   logic [63:0] m_data;
   logic [7:0]  m_par;

   always #2 clk = ~clk;

   ecc_fault_capture u0 (
      .clk(clk), .rst_n(rst_n), .sbe_strobe(sbe_strobe), .dbe_strobe(dbe_strobe),
      .fault_addr(fault_addr), .fault_data(fault_data), .fault_par(fault_par),
      .wide_sel(wide_sel), .sbe_clr(sbe_clr), .dbe_clr(dbe_clr),
      .win_idx(win_idx), .win_rdata(win_rdata), .sbe_flag(sbe_flag), .dbe_flag(dbe_flag)
   );

   function automatic logic [15:0] exp_win(input int i);
      case (i)
         0: return {m_par, 1'b0, m_addr[22:16]};
         1: return m_addr[15:0];
         2, 3, 4, 5: return m_data[(i-2)*16 +: 16];
         default: return 16'h0000;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_flags(input string tag);
      chk({tag, " sbe_flag"}, 64'(sbe_flag), 64'(m_sf));
      chk({tag, " dbe_flag"}, 64'(dbe_flag), 64'(m_df));
   endtask

   // R9 idx 0/1, R10 and R12 idx 2..5, R11 idx 6/7
   task automatic check_win(input string tag);
      for (int i = 0; i < 8; i++) begin
         string rq;
         @(negedge clk);
         win_idx = 3'(i);
         #1;
         rq = (i < 2) ? "R9" : (i < 6) ? "R10/R12" : "R11";
         chk($sformatf("%s %s idx%0d", tag, rq, i), 64'(win_rdata), 64'(exp_win(i)));
      end
   endtask

   // One stimulus cycle; the reference is updated from the requirements
   task automatic apply(input bit s, input bit d, input bit sc, input bit dc,
                        input logic [22:0] a, input logic [63:0] dt,
                        input logic [7:0] p, input bit w);
      bit td, ts;
      @(negedge clk);
      sbe_strobe = s; dbe_strobe = d; sbe_clr = sc; dbe_clr = dc;
      fault_addr = a; fault_data = dt; fault_par = p; wide_sel = w;
      td = d && !m_df && !dc;                          // R2, R8
      ts = s && !m_sf && !sc && !m_df && !td;          // R3..R6
      if (td || ts) begin
         m_addr = a;
         m_data = w ? dt : {48'h0, dt[15:0]};           // R12
         m_par  = w ? p : {2'b00, p[5:0]};
      end
      if (sc) m_sf = 1'b0; else if (ts) m_sf = 1'b1;
      if (dc) m_df = 1'b0; else if (td) m_df = 1'b1;
      @(negedge clk);
      sbe_strobe = 1'b0; dbe_strobe = 1'b0; sbe_clr = 1'b0; dbe_clr = 1'b0;
   endtask

   initial begin
      int unsigned seed;
      seed = 32'd20240611;
      void'($urandom(seed));
      m_sf = 0; m_df = 0; m_addr = '0; m_data = '0; m_par = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_flags("R1 reset");
      check_win("R1 reset");

      // R3: first single-bit fault, wide type
      apply(1, 0, 0, 0, 23'h5A_1234, 64'hDEAD_BEEF_CAFE_F00D, 8'hE7, 1);
      check_flags("R3 sbe capture");
      check_win("R3 sbe capture");
      // R4: later single-bit fault is ignored
      apply(1, 0, 0, 0, 23'h01_0101, 64'h1111_2222_3333_4444, 8'h11, 1);
      check_flags("R4 sbe hold");
      check_win("R4 sbe hold");
      // R7 + R12: double-bit fault on narrow type overwrites
      apply(0, 1, 0, 0, 23'h7F_FFFF, 64'hAAAA_BBBB_CCCC_9876, 8'hFF, 0);
      check_flags("R7 dbe overwrite");
      check_win("R7 R12 narrow record");
      // R5: both kinds ignored while double-bit record held
      apply(1, 1, 0, 0, 23'h00_0042, 64'h0, 8'h00, 1);
      check_flags("R5 dbe hold");
      check_win("R5 dbe hold");
      // R8: clear wins over same-cycle double-bit strobe
      apply(0, 1, 0, 1, 23'h12_3456, 64'h5555_5555_5555_5555, 8'h55, 1);
      check_flags("R8 clear wins");
      check_win("R8 clear wins");
      apply(0, 0, 1, 0, 23'h0, 64'h0, 8'h0, 1);
      check_flags("R8 sbe clear");
      // R6 + R2: simultaneous strobes record the double-bit fault
      apply(1, 1, 0, 0, 23'h2B_CDEF, 64'h0123_4567_89AB_CDEF, 8'hC3, 1);
      check_flags("R6 R2 simultaneous");
      check_win("R6 R2 simultaneous");
      apply(0, 0, 1, 1, 23'h0, 64'h0, 8'h0, 1);
      check_flags("R8 both clear");

      // Constrained random traffic
      for (int n = 0; n < 400; n++) begin
         bit s, d, sc, dc, w;
         s  = ($urandom % 3) == 0;
         d  = ($urandom % 5) == 0;
         sc = ($urandom % 6) == 0;
         dc = ($urandom % 7) == 0;
         w  = $urandom % 2;
         apply(s, d, sc, dc, 23'($urandom), {$urandom, $urandom}, 8'($urandom), w);
         check_flags("R2-R8 random");
         check_win("random window");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule